// File: doc/BRIEF.md
# Quasi-cyclic LDPC accumulator encoder

This block turns a 184-bit information block into a 736-bit rate-1/4 systematic LDPC codeword. Information bits arrive one per handshake on a valid/ready input, after a start pulse. Each accepted bit is forwarded straight to the serial output. It is also XOR-folded into a 552-entry parity accumulator at a small set of addresses.

Bits are taken in groups of eight. Each group selects one row of a parameter-generated base-address table. The bit's position inside the group, m, rotates every base address by m·69 modulo 552. Once the last information bit is in, the block streams the 552 parity bits. Each one is the running XOR of the accumulators up to its index, which is the dual-staircase finishing step. A one-cycle done flag closes the frame.

Top module: `ldpc_qc_encoder`

## Requirements
- R1: Directly after reset, out_valid, done and in_ready are all low.
- R2: in_ready goes high in the cycle after an accepted start. It stays high until the 184th information bit is accepted, then it is low. A bit is accepted on a rising clock edge where in_valid and in_ready are both high.
- R3: Each accepted information bit appears on out_bit, with out_valid high, in the cycle after its acceptance. The order of input is kept, so codeword bits 0..183 equal the information bits.
- R4: Information bit n belongs to group r = n/8 with offset m = n mod 8. It is XORed into the accumulator at every address (T[r][j] + 69·m) mod 552, for j = 0..2. The default table is T[r][j] = (97·r + 191·j + 11) mod 552. Two hits on the same address cancel.
- R5: After the information bits, out_valid is high for 552 consecutive cycles carrying p0..p551. Here p_i is the XOR of accumulators 0..i.
- R6: All 552 accumulators are zero at every accepted start, so a block's parity never depends on earlier blocks.
- R7: Exactly 736 bits are emitted with out_valid per block.
- R8: done is high for exactly one cycle, in the cycle right after the cycle that carries p551.
- R9: A start pulse while a block is being loaded or emitted has no effect.
- R10: Every codeword satisfies p_i ⊕ p_(i-1) ⊕ (XOR of the information bits mapped to address i by R4) = 0, for every i, with p_(-1) = 0.
- R11: in_valid while in_ready is low is ignored: nothing is emitted and nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new block (acted on only when idle) |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block is accepting information bits |
| in_bit | input | 1 | Information bit value |
| out_valid | output | 1 | out_bit carries a codeword bit |
| out_bit | output | 1 | Serial codeword bit |
| done | output | 1 | One-cycle end-of-codeword flag |

## Verification
The bench aims single-bit inputs at the first bit of the first group and the last bit of the last group (m = 7, the largest rotation). These expose an off-by-one in the modulo reduction or a rotation that uses the wrong group row. All-ones and random blocks make many addresses collide, so a design that overwrites instead of XOR-folding on duplicate addresses would emit wrong parity. Start pulses are injected both during loading and during parity streaming. A design that restarted would clear its accumulators or reopen in_ready, corrupting the frame or its length. Gaps in in_valid and stray in_valid while idle catch a design that counts unaccepted bits. Each frame is also checked against the parity-check equations, independently of the reference encoding.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PAR,
    ST_FIN
  } enc_state_t;

  // Base parity address for table row `row`, entry `col`.
  function automatic int base_addr(input int row, input int col, input int a_row,
                                   input int a_col, input int a_off, input int modv);
    return (row * a_row + col * a_col + a_off) % modv;
  endfunction

endpackage

// File: rtl/ldpc_addr_rom.sv
module ldpc_addr_rom #(
  parameter int PAR_LEN = 552,
  parameter int ROWS    = 23,
  parameter int ROW_LEN = 3,
  parameter int A_ROW   = 97,
  parameter int A_COL   = 191,
  parameter int A_OFF   = 11,
  parameter int AW      = 10,
  parameter int GW      = 5
) (
  input  logic [GW-1:0]         row_i,
  output logic [ROW_LEN*AW-1:0] base_o
);

  function automatic logic [ROW_LEN*AW-1:0] row_word(input int r);
    logic [ROW_LEN*AW-1:0] w;
    w = '0;
    for (int j = 0; j < ROW_LEN; j++) begin
      w[j*AW +: AW] = AW'(ldpc_enc_pkg::base_addr(r, j, A_ROW, A_COL, A_OFF, PAR_LEN));
    end
    return w;
  endfunction

  logic [ROW_LEN*AW-1:0] tbl [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign tbl[r] = row_word(r);
  end

  always_comb begin
    if (int'(row_i) < ROWS) base_o = tbl[row_i];
    else                    base_o = '0;
  end

endmodule

// File: rtl/ldpc_addr_rotate.sv
module ldpc_addr_rotate #(
  parameter int PAR_LEN = 552,
  parameter int ROW_LEN = 3,
  parameter int Q       = 69,
  parameter int AW      = 10,
  parameter int SW      = 3
) (
  input  logic [ROW_LEN*AW-1:0] base_i,
  input  logic [SW-1:0]         sub_i,
  output logic [ROW_LEN*AW-1:0] addr_o
);

  localparam logic [AW:0] MODV = (AW+1)'(PAR_LEN);
  localparam logic [AW:0] QV   = (AW+1)'(Q);

  logic [AW:0] off;
  assign off = (AW+1)'(sub_i) * QV;

  for (genvar j = 0; j < ROW_LEN; j++) begin : g_ent
    logic [AW:0] sum;
    assign sum = {1'b0, base_i[j*AW +: AW]} + off;
    // both terms are below the modulus, one subtraction suffices
    assign addr_o[j*AW +: AW] = (sum >= MODV) ? AW'(sum - MODV) : sum[AW-1:0];
  end

endmodule

// File: rtl/ldpc_parity_store.sv
module ldpc_parity_store #(
  parameter int PAR_LEN = 552,
  parameter int ROW_LEN = 3,
  parameter int AW      = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  acc_en_i,
  input  logic                  acc_bit_i,
  input  logic [ROW_LEN*AW-1:0] addr_i,
  input  logic [AW-1:0]         rd_idx_i,
  output logic                  rd_bit_o
);

  logic [PAR_LEN-1:0] acc_q;
  logic [PAR_LEN-1:0] hit;

  // GF(2) hit mask: a repeated address toggles twice and cancels
  always_comb begin
    hit = '0;
    for (int j = 0; j < ROW_LEN; j++) begin
      hit[addr_i[j*AW +: AW]] = ~hit[addr_i[j*AW +: AW]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q <= '0;
    end else if (acc_en_i && acc_bit_i) begin
      acc_q <= acc_q ^ hit;
    end
  end

  assign rd_bit_o = acc_q[rd_idx_i];

endmodule

// File: rtl/ldpc_qc_encoder.sv
module ldpc_qc_encoder #(
  parameter int INFO_LEN = 184,
  parameter int PAR_LEN  = 552,
  parameter int GRP      = 8,
  parameter int Q        = 69,
  parameter int ROW_LEN  = 3,
  parameter int A_ROW    = 97,
  parameter int A_COL    = 191,
  parameter int A_OFF    = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit,
  output logic done
);

  import ldpc_enc_pkg::*;

  localparam int ROWS = INFO_LEN / GRP;
  localparam int AW   = $clog2(PAR_LEN);
  localparam int GW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int SW   = (GRP > 1) ? $clog2(GRP) : 1;

  enc_state_t            st;
  logic [GW-1:0]         grp;
  logic [SW-1:0]         sub;
  logic [AW-1:0]         pidx;
  logic                  run;
  logic [ROW_LEN*AW-1:0] base_addrs;
  logic [ROW_LEN*AW-1:0] rot_addrs;
  logic                  rd_bit;
  logic                  accept;
  logic                  last_info;
  logic                  clr;

  assign in_ready  = (st == ST_LOAD);
  assign accept    = in_ready && in_valid;
  assign last_info = (grp == GW'(ROWS - 1)) && (sub == SW'(GRP - 1));
  assign clr       = (st == ST_IDLE) && start;

  ldpc_addr_rom #(
    .PAR_LEN(PAR_LEN), .ROWS(ROWS), .ROW_LEN(ROW_LEN),
    .A_ROW(A_ROW), .A_COL(A_COL), .A_OFF(A_OFF), .AW(AW), .GW(GW)
  ) u_rom (
    .row_i (grp),
    .base_o(base_addrs)
  );

  ldpc_addr_rotate #(
    .PAR_LEN(PAR_LEN), .ROW_LEN(ROW_LEN), .Q(Q), .AW(AW), .SW(SW)
  ) u_rot (
    .base_i(base_addrs),
    .sub_i (sub),
    .addr_o(rot_addrs)
  );

  ldpc_parity_store #(
    .PAR_LEN(PAR_LEN), .ROW_LEN(ROW_LEN), .AW(AW)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .acc_en_i (accept),
    .acc_bit_i(in_bit),
    .addr_i   (rot_addrs),
    .rd_idx_i (pidx),
    .rd_bit_o (rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      grp       <= '0;
      sub       <= '0;
      pidx      <= '0;
      run       <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st  <= ST_LOAD;
            grp <= '0;
            sub <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            out_valid <= 1'b1;
            out_bit   <= in_bit;
            if (sub == SW'(GRP - 1)) begin
              sub <= '0;
              grp <= grp + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
            if (last_info) begin
              st   <= ST_PAR;
              pidx <= '0;
              run  <= 1'b0;
            end
          end
        end
        ST_PAR: begin
          // staircase pass folded into the output stream
          out_valid <= 1'b1;
          out_bit   <= run ^ rd_bit;
          run       <= run ^ rd_bit;
          if (pidx == AW'(PAR_LEN - 1)) st <= ST_FIN;
          else                          pidx <= pidx + 1'b1;
        end
        default: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ldpc_qc_encoder_chk.sv
module ldpc_qc_encoder_chk #(
  parameter int INFO_LEN = 184,
  parameter int PAR_LEN  = 552
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic done
);

  localparam int N  = INFO_LEN + PAR_LEN;
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] ocnt;
  logic [CW-1:0] icnt;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      ocnt <= '0;
      icnt <= '0;
    end else begin
      if (out_valid)            ocnt <= ocnt + 1'b1;
      if (in_valid && in_ready) icnt <= icnt + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !done && !in_ready));

  a_r2_accept_bound: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (icnt < CW'(INFO_LEN)));

  a_r2_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  a_r7_no_excess_output: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ocnt < CW'(N)));

  a_r7_count_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (ocnt == CW'(N)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_valid) && !out_valid));

  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

endmodule

bind ldpc_qc_encoder ldpc_qc_encoder_chk #(
  .INFO_LEN(INFO_LEN), .PAR_LEN(PAR_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .done     (done)
);

// File: tb/tb_ldpc_qc_encoder.sv
`timescale 1ns/1ps
module tb_ldpc_qc_encoder;

  localparam int K = 184;
  localparam int M = 552;
  localparam int N = K + M;

  logic clk = 1'b0;
  logic rst, start, in_valid, in_bit;
  logic in_ready, out_valid, out_bit, done;

  always #10 clk = ~clk;  // 50 MHz

  ldpc_qc_encoder dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit), .done(done)
  );

  int total = 0;
  int bad = 0;
  int blocks_issued = 0;
  int blocks_done = 0;

  bit           expq[$];
  logic [N-1:0] expw[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tbl(input int r, input int j);
    return (97 * r + 191 * j + 11) % 552;
  endfunction

  // reference encoder built from R3, R4, R5
  function automatic logic [N-1:0] ref_code(input logic [K-1:0] info);
    logic [M-1:0] acc;
    logic [N-1:0] w;
    logic         run;
    int           a;
    acc = '0;
    for (int n = 0; n < K; n++) begin
      for (int j = 0; j < 3; j++) begin
        a = (tbl(n / 8, j) + (n % 8) * 69) % 552;
        acc[a] ^= info[n];
      end
    end
    w = '0;
    for (int n = 0; n < K; n++) w[n] = info[n];
    run = 1'b0;
    for (int i = 0; i < M; i++) begin
      run = run ^ acc[i];
      w[K+i] = run;
    end
    return w;
  endfunction

  // R10: number of unsatisfied parity checks in a received word
  function automatic int syn_weight(input logic [N-1:0] w);
    logic [M-1:0] s;
    int           a;
    int           cnt;
    s = '0;
    for (int n = 0; n < K; n++) begin
      for (int j = 0; j < 3; j++) begin
        a = (tbl(n / 8, j) + (n % 8) * 69) % 552;
        s[a] ^= w[n];
      end
    end
    for (int i = 0; i < M; i++) begin
      s[i] ^= w[K+i];
      if (i > 0) s[i] ^= w[K+i-1];
    end
    cnt = 0;
    for (int i = 0; i < M; i++) cnt += int'(s[i]);
    return cnt;
  endfunction

  // monitor / scoreboard
  int           idx = 0;
  logic [N-1:0] rxw = '0;
  bit           prev_valid = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected output bit", idx, N);
        end else begin
          bit e;
          e = expq.pop_front();
          if (idx < K) chk(out_bit == e, "R3 systematic bit", out_bit, e);
          else         chk(out_bit == e, "R4 R5 parity bit", out_bit, e);
          if (idx < N) rxw[idx] = out_bit;
          idx++;
        end
      end
      if (done) begin
        logic [N-1:0] ew;
        chk(prev_valid && !out_valid && idx == N, "R8 done after last parity bit", idx, N);
        chk(syn_weight(rxw) == 0, "R10 parity checks satisfied", syn_weight(rxw), 0);
        ew = (expw.size() > 0) ? expw.pop_front() : '0;
        chk(rxw == ew, "R6 block equals fresh-start model", $countones(rxw ^ ew), 0);
        idx = 0;
        blocks_done++;
      end
      prev_valid = out_valid;
    end
  end

  // driver
  task automatic run_block(input logic [K-1:0] info, input bit gaps, input bit inject);
    logic [N-1:0] w;
    int           target;
    w = ref_code(info);
    for (int i = 0; i < N; i++) expq.push_back(w[i]);
    expw.push_back(w);
    blocks_issued++;
    target = blocks_issued;

    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready after start", in_ready, 1);
    @(posedge clk); #1;

    for (int n = 0; n < K; n++) begin
      in_valid = 1'b1;
      in_bit   = info[n];
      if (inject && n == 50) start = 1'b1;  // R9: start during loading
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1 start = 1'b0;
      if (gaps && (n % 7 == 3)) begin
        in_valid = 1'b0;
        repeat (n % 3 + 1) @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 ready drops after last info bit", in_ready, 0);

    if (inject) begin
      repeat (100) @(posedge clk);
      #1 start = 1'b1;  // R9: start during parity streaming
      @(posedge clk); #1 start = 1'b0;
    end

    while (blocks_done < target) @(posedge clk);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(!in_ready && !out_valid, "R9 start ignored while busy", {in_ready, out_valid}, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R7 watchdog expired", blocks_done, blocks_issued);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [K-1:0] v;
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);

    // R11: stray input while idle
    in_valid = 1'b1; in_bit = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(!out_valid && !in_ready, "R11 stray input ignored", {out_valid, in_ready}, 0);
    end
    @(posedge clk); #1 in_valid = 1'b0;

    run_block('0, 1'b0, 1'b0);                      // all zeros
    run_block('1, 1'b0, 1'b0);                      // all ones (R6 next)
    v = '0; v[0] = 1'b1;
    run_block(v, 1'b0, 1'b0);                       // first bit, first group
    v = '0; v[K-1] = 1'b1;
    run_block(v, 1'b1, 1'b0);                       // last bit, m = 7
    for (int i = 0; i < K; i++) v[i] = 1'(((i * 5) % 8) < 3);
    run_block(v, 1'b1, 1'b0);                       // patterned, gaps
    for (int i = 0; i < K; i++) v[i] = 1'($urandom & 1);
    run_block(v, 1'b1, 1'b1);                       // random, start injected
    for (int i = 0; i < K; i++) v[i] = 1'($urandom & 1);
    run_block(v, 1'b0, 1'b0);                       // random, back to back

    chk(expq.size() == 0, "R7 all expected bits emitted", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule